// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an asynchronous static RAM of 512K bytes. The host issues one read or one write at a time through a request/ready handshake. The sequencer then produces the chip-enable, write-enable and output-enable pulses, the address and the data-bus direction that the memory's timing rules require. Every strobe width and wait is counted in clock cycles. Each cycle count is derived from a nanosecond limit and a clock-period parameter: ceiling division, with a floor of one cycle. Slower speed grades therefore need only new parameter values.

A read holds chip enable and output enable low for the whole access window. The returned byte is registered in the last cycle of that window and handed to the host with a one-cycle valid pulse. A read always ends with a turnaround wait, so the memory's drivers have let go of the bus before the controller can drive it again.

A write has three phases:
- setup: the address is placed and the data is driven;
- pulse: write enable is held low;
- hold: write enable has risen while the data and the address are still held.

Output enable stays high for the whole of a write. The address register changes only while chip enable is high.

The controller uses six states:
- IDLE
- WR_SETUP
- WR_PULSE
- WR_HOLD
- RD_ACCESS
- RD_TURN

It moves between them as follows:
- IDLE goes to WR_SETUP when a write request is accepted, and to RD_ACCESS when a read request is accepted.
- WR_SETUP goes to WR_PULSE after one cycle.
- WR_PULSE goes to WR_HOLD when the write-pulse timer expires.
- WR_HOLD returns to IDLE when the recovery timer expires.
- RD_ACCESS goes to RD_TURN when the access timer expires, capturing the data on the way.
- RD_TURN returns to IDLE when the turnaround timer expires.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, host_ready is 1 and host_rvalid is 0.
- R2: A request is accepted on a clock edge where host_req and host_ready are both 1, and host_ready is 0 in the next cycle. With a 10 ns clock, host_ready returns to 1 eight cycles after a write is accepted and nine cycles after a read is accepted, and mem_ce_n is 1 in that cycle.
- R3: mem_addr equals the address of the accepted request, and it never changes between two consecutive cycles in which mem_ce_n is 0.
- R4: During a write, mem_oe_n stays 1 whenever mem_we_n is 0, and the memory stores the data that was on host_wdata at acceptance, even if host_wdata changes afterwards.
- R5: During a write, mem_we_n is low for exactly WP cycles, where WP is the largest of ceil(45 ns/period), ceil(50 ns/period) and ceil(25 ns/period). That is 5 cycles at 10 ns. The pulse is preceded by one setup cycle with mem_ce_n at 0, mem_we_n at 1 and the data already driven.
- R6: During a read, mem_ce_n and mem_oe_n are both 0 for exactly RD cycles, where RD is the largest of ceil(55 ns/period) and ceil(30 ns/period). That is 6 cycles at 10 ns. The data present in the last of these cycles appears on host_rdata, and host_rvalid is 1 for exactly one cycle, the seventh after acceptance.
- R7: mem_dq_oe is never 1 while mem_oe_n is 0. After a read, mem_dq_oe stays 0 for at least TA = ceil(20 ns/period) cycles (2 at 10 ns) counted from the rise of mem_oe_n.
- R8: host_rdata holds the last read byte through later writes, and host_wdata has no effect on a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Byte address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | Controller idle, request may be accepted |
| host_rdata | output | 8 | Last read byte |
| host_rvalid | output | 1 | One-cycle pulse: host_rdata is new |
| mem_addr | output | 19 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_in | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable of mem_dq_out |

## Verification
The assertions take for granted that mem_dq_in carries valid data no later than the access time. They also assume the host presents host_req only when host_ready is high. Apart from reset, the assertions make no assumption about host_wr, host_addr or host_wdata. The bench drives each request for one cycle, starting when host_ready is 1, and releases it in the cycle after acceptance. The bench's memory model returns the complement of the stored byte until the read address has been stable for the full access time, so sampling too early is caught.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_TURN
    } seq_state_t;

    // Nanoseconds to whole clock cycles, rounded up, at least one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) begin
                rdata <= din;
            end
        end
    end

    // R6: a valid pulse is never longer than one cycle
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int RD_CYC   = 6,
    parameter int WP_CYC   = 5,
    parameter int HOLD_CYC = 1,
    parameter int TA_CYC   = 2,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_wr,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output logic             ce_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);
    localparam logic [CNT_W-1:0] SETUP_V = '0;
    localparam logic [CNT_W-1:0] RD_V    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WP_V    = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_V  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] TA_V    = CNT_W'(TA_CYC - 1);

    seq_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (host_wr) begin
                        state_d = ST_WR_SETUP;
                        tmr_val = SETUP_V;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        tmr_val = RD_V;
                    end
                end
            end
            ST_WR_SETUP: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = WP_V;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_V;
                end
            end
            ST_WR_HOLD: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_expired) begin
                    state_d  = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = TA_V;
                end
            end
            ST_RD_TURN: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Strobe decode per state
    always_comb begin
        ready   = 1'b0;
        ce_n    = 1'b1;
        we_n    = 1'b1;
        oe_n    = 1'b1;
        dq_oe   = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE:      ready = 1'b1;
            ST_WR_SETUP:  begin ce_n = 1'b0; dq_oe = 1'b1; end
            ST_WR_PULSE:  begin ce_n = 1'b0; we_n = 1'b0; dq_oe = 1'b1; end
            ST_WR_HOLD:   begin ce_n = 1'b0; dq_oe = 1'b1; end
            ST_RD_ACCESS: begin ce_n = 1'b0; oe_n = 1'b0; capture = tmr_expired; end
            ST_RD_TURN:   ;
            default:      ;
        endcase
    end

    // R2: an accepted request makes the controller busy in the next cycle
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && ready) |=> !ready);

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_RC_NS       = 55,
    parameter int T_AA_NS       = 55,
    parameter int T_OE_NS       = 30,
    parameter int T_WC_NS       = 55,
    parameter int T_WP_NS       = 45,
    parameter int T_AW_NS       = 50,
    parameter int T_DW_NS       = 25,
    parameter int T_HZ_NS       = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int RD_CYC   = max2(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                              max2(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)));
    localparam int WP_CYC   = max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                              max2(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS),
                                   ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)));
    localparam int WC_CYC   = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC = max2(1, WC_CYC - 1 - WP_CYC);
    localparam int TA_CYC   = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC  = max2(max2(RD_CYC, WP_CYC), max2(HOLD_CYC, TA_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1) + 1;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             accept;
    logic             capture;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_seq_fsm #(
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .HOLD_CYC (HOLD_CYC),
        .TA_CYC   (TA_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_wr     (host_wr),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .capture     (capture),
        .ready       (host_ready),
        .ce_n        (mem_ce_n),
        .we_n        (mem_we_n),
        .oe_n        (mem_oe_n),
        .dq_oe       (mem_dq_oe)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .din     (mem_dq_in),
        .rdata   (host_rdata),
        .rvalid  (host_rvalid)
    );

    // Request latch: loads only on acceptance, which happens in IDLE (chip enable high)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    // Checker-side counters for strobe windows
    logic [CNT_W-1:0] oe_hi_cnt;
    logic [CNT_W-1:0] we_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_hi_cnt <= '1;
            we_lo_cnt <= '0;
        end else begin
            if (!mem_oe_n)            oe_hi_cnt <= '0;
            else if (oe_hi_cnt != '1) oe_hi_cnt <= oe_hi_cnt + 1'b1;
            if (mem_we_n)             we_lo_cnt <= '0;
            else if (we_lo_cnt != '1) we_lo_cnt <= we_lo_cnt + 1'b1;
        end
    end

    // R4: output enable never low while write enable is low
    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R3: address steady across consecutive selected cycles
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R7: data bus never driven while the memory's outputs are enabled
    a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R7: turnaround gap before the controller drives the bus
    a_r7_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_hi_cnt >= CNT_W'(TA_CYC)));

    // R5: write pulse lasts exactly the derived width
    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_lo_cnt == CNT_W'(WP_CYC)));

endmodule

// File: tb/sram_seq_ctrl_tb.sv
module sram_seq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [18:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sram_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // Memory model and protocol monitor, sampled at falling edges
    logic [7:0] model_mem [logic [18:0]];
    logic        prev_ce = 1, prev_we = 1, prev_rd = 0, prev_oe_drv = 0;
    logic [18:0] prev_addr = '0;
    logic [7:0]  prev_dq = '0;
    int rd_age = 0, we_run = 0, rd_run = 0, oe_hi_run = 100;
    int last_wp_len = 0, last_rd_len = 0;
    int viol_r3 = 0, viol_r4 = 0, viol_r7 = 0;

    always @(negedge clk) begin
        logic rd_now;
        logic [7:0] val;
        if (rst_n) begin
            rd_now = !mem_ce_n && !mem_oe_n && mem_we_n;
            if (!mem_we_n && !mem_oe_n) viol_r4++;
            if (!mem_ce_n && !prev_ce && mem_addr != prev_addr) viol_r3++;
            if (mem_dq_oe && !mem_oe_n) viol_r7++;
            if (mem_oe_n) oe_hi_run++; else oe_hi_run = 0;
            if (mem_dq_oe && !prev_oe_drv && oe_hi_run < 3) viol_r7++;
            // write commits when chip enable or write enable rises first
            if (!prev_ce && !prev_we && (mem_ce_n || mem_we_n))
                model_mem[prev_addr] = prev_dq;
            if (!mem_we_n) we_run++;
            else if (we_run > 0) begin last_wp_len = we_run; we_run = 0; end
            if (rd_now) rd_run++;
            else if (rd_run > 0) begin last_rd_len = rd_run; rd_run = 0; end
            if (rd_now && prev_rd && mem_addr == prev_addr) rd_age++;
            else rd_age = rd_now ? 1 : 0;
            val = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'h00;
            mem_dq_in <= (rd_age >= 6) ? val : ~val;
            prev_ce = mem_ce_n; prev_we = mem_we_n; prev_rd = rd_now;
            prev_addr = mem_addr; prev_dq = mem_dq_out; prev_oe_drv = mem_dq_oe;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "strobes ce/we/oe", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
        chk("R1", "dq_oe", mem_dq_oe, 0);
        chk("R1", "ready", host_ready, 1);
        chk("R1", "rvalid", host_rvalid, 0);
    endtask

    task automatic t_write(input logic [18:0] a, input logic [7:0] d);
        int n = 0;
        host_req = 1; host_wr = 1; host_addr = a; host_wdata = d;
        do begin
            @(negedge clk); n++;
            if (n == 1) begin
                host_req = 0; host_wdata = ~d; host_addr = ~a;
                chk("R2", "busy after write accept", host_ready, 0);
                chk("R3", "address on bus", mem_addr, a);
                chk("R5", "setup ce/we/dq_oe", {mem_ce_n, mem_we_n, mem_dq_oe}, 3'b011);
            end
        end while (!host_ready && n < 50);
        chk("R2", "write latency", n, 8);
        chk("R2", "ce high at ready", mem_ce_n, 1);
        chk("R5", "write pulse width", last_wp_len, 5);
        chk("R4", "stored byte", model_mem.exists(a) ? model_mem[a] : 9'h100, d);
    endtask

    task automatic t_read(input logic [18:0] a, input logic [7:0] exp);
        int n = 0, seen = -1, pulses = 0;
        host_req = 1; host_wr = 0; host_addr = a; host_wdata = ~exp;
        do begin
            @(negedge clk); n++;
            if (n == 1) begin
                host_req = 0; host_addr = ~a; host_wdata = 8'h5A;
                chk("R2", "busy after read accept", host_ready, 0);
                chk("R3", "address on bus", mem_addr, a);
            end
            if (host_rvalid) begin
                pulses++;
                if (seen < 0) seen = n;
            end
        end while (!host_ready && n < 50);
        chk("R6", "rvalid cycle", seen, 7);
        chk("R6", "rvalid pulse count", pulses, 1);
        chk("R6", "read data", host_rdata, exp);
        chk("R6", "access window", last_rd_len, 6);
        chk("R2", "read latency", n, 9);
    endtask

    task automatic t_hold_after_write(input logic [7:0] last_rd);
        t_write(19'h2AAAA, 8'hC3);
        chk("R8", "rdata held over write", host_rdata, last_rd);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write(19'h00000, 8'hA5);
        t_read (19'h00000, 8'hA5);
        t_write(19'h7FFFF, 8'hFF);
        t_write(19'h12345, 8'h00);
        t_read (19'h7FFFF, 8'hFF);
        t_read (19'h12345, 8'h00);
        t_write(19'h00001, 8'h3C);
        t_read (19'h00001, 8'h3C);
        t_hold_after_write(8'h3C);
        t_read (19'h2AAAA, 8'hC3);
        chk("R3", "address changes while selected", viol_r3, 0);
        chk("R4", "oe low during write", viol_r4, 0);
        chk("R7", "bus drive or turnaround violations", viol_r7, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule